// File: doc/BRIEF.md
# Device Interrupt Status Controller

This block gathers single-cycle event pulses from the endpoint and bus logic of a USB device function and turns them into one interrupt request for the local CPU. Each event sets a sticky status bit. The bits sit in two status registers. The CPU acknowledges an event by writing 1 to its bit. Two enable registers choose which pending events drive the interrupt line. The second enable register also stores the data-toggle mode bits of three endpoints.

The first status register carries a read-only summary bit. It tells the CPU that something is pending in the second status register, so a handler can read the first register and look at the second one only when needed. A built-in idle timer counts 1 ms ticks and raises the suspend event once the bus has been quiet for longer than the configured number of milliseconds.

The completion event of the interrupt IN endpoint depends on that endpoint's toggle mode. In mode 0 it needs a host acknowledge. In mode 1 every finished transaction counts.

Top module: `irq_status_ctrl`

## Requirements
- R1: The CPU port has four registers, selected by address. Writes to address 0 (group-A enables) keep all 8 bits. Writes to address 1 (group-B enables) keep bits 6:0, and bit 7 reads 0. Group-A enable bits 5:0 pair with group-A status bits 5:0. Group-A enable bit 6 pairs with EP0 transmit done and bit 7 with EP0 receive done. Group-B enable bits 0..3 pair with EP0 error, bus reset, start of frame and suspend. Group-B bits 4, 5 and 6 are the toggle modes of the interrupt IN, bulk OUT and bulk IN endpoints.
- R2: After a synchronous active-high reset, all enable and status bits read 0 and the interrupt output is 0.
- R3: An event pulse sets its status bit, and the bit stays set. Group-A status at address 2: bit0 bulk IN sent, bit1 bulk OUT received, bit2 IN watermark, bit3 OUT watermark, bit4 SETUP received, bit5 interrupt IN sent. Group-B status at address 3: bit0 EP0 transmit done, bit1 EP0 receive done, bit2 EP0 error, bit3 bus reset, bit4 start of frame, bit5 suspend. Event input bits 4:0 map to status bits 4:0 of their group.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A status write never sets a bit.
- R5: When an event pulse and a write-1-to-clear reach the same bit in the same cycle, the bit ends set.
- R6: Bit 6 of address 2 is read-only. It equals the OR of group-B status bits 5:0, and writes to it are ignored.
- R7: The suspend status sets when tick IDLE_TICKS+1 arrives with no bus activity since the last activity or reset. It sets once per idle period. Activity restarts the count, and activity wins over a tick in the same cycle.
- R8: The interrupt output is registered. It is 1 in the cycle after any status bit is set together with its enable bit, and 0 otherwise.
- R9: With toggle-mode bit 4 at 0, interrupt IN sent status sets only when transaction done comes with host ACK. With that bit at 1, it sets on every done pulse.
- R10: Read data is registered: the register selected by the address in one cycle appears on the read-data output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_a_i | input | 5 | Group-A event pulses, mapped to status bits 4:0 |
| evt_b_i | input | 5 | Group-B event pulses, mapped to status bits 4:0 |
| intr_in_done_i | input | 1 | Interrupt IN transaction finished |
| intr_in_ack_i | input | 1 | Host acknowledged that transaction |
| bus_active_i | input | 1 | Bus activity seen this cycle |
| tick_1ms_i | input | 1 | One-cycle pulse every millisecond |
| cpu_addr_i | input | 2 | Register select |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with IDLE_TICKS at its default of 5. The suspend threshold can then be crossed, and restarted by activity, in a few dozen cycles of tick pulses. That window puts the exact boundary in reach: silence after five ticks, the event on the sixth, and no second event while idling continues. A vector table covers the enable-to-status pairings, and these cases are tested separately: the clear/set collision, the read-only summary, and both toggle modes of the interrupt endpoint.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DW      = 8;
  localparam int EVW     = 5;   // pulse inputs per group
  localparam int STW     = 6;   // stored status bits per group
  localparam int ENB_W   = 7;   // implemented bits of group-B enable
  localparam int SUM_BIT = 6;   // read-only summary in group-A status
  localparam int INTR_SENT_BIT = 5;
  localparam int SUSP_BIT      = 5;
  localparam int TGL_INTR_BIT  = 4;

  typedef enum logic [1:0] {
    ADDR_EN_A = 2'd0,
    ADDR_EN_B = 2'd1,
    ADDR_ST_A = 2'd2,
    ADDR_ST_B = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;

  // R3: without a clear, no set bit drops
  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (clr_i == '0) |=> ((q_o & $past(q_o)) == $past(q_o)));

  // R5: a pulsed bit is set afterwards, whatever the clear did
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_idle_timer.sv
module irq_idle_timer #(
  parameter int IDLE_TICKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic active_i,
  output logic susp_o
);
  localparam int LIMIT = IDLE_TICKS + 1;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                                   cnt <= '0;
    else if (active_i)                         cnt <= '0;
    else if (tick_i && cnt != CW'(LIMIT))      cnt <= cnt + 1'b1;
  end

  assign susp_o = tick_i && !active_i && (cnt == CW'(IDLE_TICKS));

  // R7: suspend never comes with activity or without a tick
  a_r7_idle_only: assert property (@(posedge clk) disable iff (rst)
    susp_o |-> (tick_i && !active_i));

  // R7: one event per idle period
  a_r7_single_event: assert property (@(posedge clk) disable iff (rst)
    susp_o |=> !susp_o);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int IDLE_TICKS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EVW-1:0] evt_a_i,
  input  logic [EVW-1:0] evt_b_i,
  input  logic          intr_in_done_i,
  input  logic          intr_in_ack_i,
  input  logic          bus_active_i,
  input  logic          tick_1ms_i,
  input  logic [1:0]    cpu_addr_i,
  input  logic          cpu_we_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          irq_o
);
  logic [DW-1:0]    en_a;
  logic [ENB_W-1:0] en_b;
  logic [STW-1:0]   st_a, st_b, set_a, set_b, clr_a, clr_b;
  logic             susp_evt, intr_sent_evt, summary;
  logic [DW-1:0]    rdata_q;
  logic             irq_q;

  // enable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_a <= '0;
      en_b <= '0;
    end else if (cpu_we_i) begin
      if (cpu_addr_i == ADDR_EN_A) en_a <= cpu_wdata_i;
      if (cpu_addr_i == ADDR_EN_B) en_b <= cpu_wdata_i[ENB_W-1:0];
    end
  end

  irq_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst(rst), .tick_i(tick_1ms_i),
    .active_i(bus_active_i), .susp_o(susp_evt)
  );

  assign intr_sent_evt = intr_in_done_i & (intr_in_ack_i | en_b[TGL_INTR_BIT]);

  always_comb begin
    set_a = {intr_sent_evt, evt_a_i};
    set_b = {susp_evt, evt_b_i};
    clr_a = (cpu_we_i && cpu_addr_i == ADDR_ST_A) ? cpu_wdata_i[STW-1:0] : '0;
    clr_b = (cpu_we_i && cpu_addr_i == ADDR_ST_B) ? cpu_wdata_i[STW-1:0] : '0;
  end

  irq_sticky_reg #(.W(STW)) u_st_a (
    .clk(clk), .rst(rst), .set_i(set_a), .clr_i(clr_a), .q_o(st_a)
  );
  irq_sticky_reg #(.W(STW)) u_st_b (
    .clk(clk), .rst(rst), .set_i(set_b), .clr_i(clr_b), .q_o(st_b)
  );

  assign summary = |st_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      unique case (cpu_addr_i)
        ADDR_EN_A: rdata_q <= en_a;
        ADDR_EN_B: rdata_q <= {1'b0, en_b};
        ADDR_ST_A: rdata_q <= {1'b0, summary, st_a};
        default:   rdata_q <= {2'b00, st_b};
      endcase
      irq_q <= (|(st_a & en_a[STW-1:0])) |
               (|(st_b[1:0] & en_a[7:6])) |
               (|(st_b[5:2] & en_b[3:0]));
    end
  end

  assign cpu_rdata_o = rdata_q;
  assign irq_o       = irq_q;

  // R2: the cycle after reset the request is low and status is clear
  a_r2_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (irq_o == 1'b0 && st_a == '0 && st_b == '0));

  // R8: with every enable off the request stays low
  a_r8_masked_low: assert property (@(posedge clk) disable iff (rst)
    (en_a == '0 && en_b[3:0] == '0) |=> !irq_o);

  // R9: in acknowledge mode an unacknowledged completion leaves a clear bit clear
  a_r9_ack_needed: assert property (@(posedge clk) disable iff (rst)
    (!en_b[TGL_INTR_BIT] && !intr_in_ack_i && !st_a[INTR_SENT_BIT])
      |=> !st_a[INTR_SENT_BIT]);
endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] evt_a = '0, evt_b = '0;
  logic       done = 1'b0, ack = 1'b0, act = 1'b0, tick = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int nchk = 0, nfail = 0, cyc = 0;

  irq_status_ctrl #(.IDLE_TICKS(5)) uut (
    .clk(clk), .rst(rst), .evt_a_i(evt_a), .evt_b_i(evt_b),
    .intr_in_done_i(done), .intr_in_ack_i(ack), .bus_active_i(act),
    .tick_1ms_i(tick), .cpu_addr_i(addr), .cpu_we_i(we),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .irq_o(irq)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic [4:0] ev_a;
    logic [4:0] ev_b;
    logic [7:0] en_a;
    logic [7:0] en_b;
    logic [7:0] exp_a;
    logic [7:0] exp_b;
    logic       exp_irq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{5'h01, 5'h00, 8'h01, 8'h00, 8'h01, 8'h00, 1'b1},
    '{5'h10, 5'h00, 8'h00, 8'h00, 8'h10, 8'h00, 1'b0},
    '{5'h00, 5'h01, 8'h40, 8'h00, 8'h40, 8'h01, 1'b1},
    '{5'h00, 5'h04, 8'h00, 8'h01, 8'h40, 8'h04, 1'b1},
    '{5'h00, 5'h10, 8'h00, 8'h02, 8'h40, 8'h10, 1'b0},
    '{5'h1F, 5'h1F, 8'hFF, 8'h0F, 8'h5F, 8'h1F, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input logic [4:0] a, input logic [4:0] b);
    @(negedge clk); evt_a = a; evt_b = b;
    @(negedge clk); evt_a = '0; evt_b = '0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic activity;
    @(negedge clk); act = 1'b1;
    @(negedge clk); act = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nchk++; nfail++;
      $display("FAIL watchdog got %0d expected <20000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    chk("R2 irq", {7'd0, irq}, 8'h00);
    for (int r = 0; r < 4; r++) begin
      rd(r[1:0], d);
      chk("R2 R10 reg after reset", d, 8'h00);
    end

    // R1 enable readback
    wr(2'd0, 8'hA5); rd(2'd0, d); chk("R1 en_a", d, 8'hA5);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R1 en_b bit7 zero", d, 8'h7F);
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);

    // vector table: R3 R8 R6
    for (int i = 0; i < 6; i++) begin
      wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
      wr(2'd0, VECS[i].en_a); wr(2'd1, VECS[i].en_b);
      pulse(VECS[i].ev_a, VECS[i].ev_b);
      @(negedge clk);
      chk("R8 vector irq", {7'd0, irq}, {7'd0, VECS[i].exp_irq});
      rd(2'd2, d); chk("R3 R6 vector st_a", d, VECS[i].exp_a);
      rd(2'd3, d); chk("R3 vector st_b", d, VECS[i].exp_b);
    end
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);

    // R4 write-one-to-clear, zero no effect
    pulse(5'h11, 5'h00);
    wr(2'd2, 8'h01); rd(2'd2, d); chk("R4 clear one bit", d, 8'h10);
    wr(2'd2, 8'h00); rd(2'd2, d); chk("R4 write zero", d, 8'h10);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R4 clear all", d, 8'h00);

    // R5 set and clear collide
    @(negedge clk); evt_a = 5'h02; addr = 2'd2; we = 1'b1; wdata = 8'h02;
    @(negedge clk); evt_a = '0; we = 1'b0;
    rd(2'd2, d); chk("R5 set wins", d, 8'h02);
    wr(2'd2, 8'hFF);

    // R6 summary is read-only
    wr(2'd2, 8'h40); rd(2'd2, d); chk("R6 summary write ignored", d, 8'h00);
    pulse(5'h00, 5'h08); rd(2'd2, d); chk("R6 summary follows group B", d, 8'h40);
    wr(2'd3, 8'hFF); rd(2'd2, d); chk("R6 summary drops", d, 8'h00);

    // R9 toggle mode of interrupt IN endpoint
    @(negedge clk); done = 1'b1; ack = 1'b0;
    @(negedge clk); done = 1'b0;
    rd(2'd2, d); chk("R9 mode0 no ack", d, 8'h00);
    @(negedge clk); done = 1'b1; ack = 1'b1;
    @(negedge clk); done = 1'b0; ack = 1'b0;
    rd(2'd2, d); chk("R9 mode0 ack", d, 8'h20);
    wr(2'd2, 8'hFF); wr(2'd1, 8'h10);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    rd(2'd2, d); chk("R9 mode1 no ack", d, 8'h20);
    wr(2'd2, 8'hFF);

    // R7 idle timer, suspend enabled for R8
    wr(2'd1, 8'h08);
    activity();
    wr(2'd3, 8'hFF);
    ticks(5);
    rd(2'd3, d); chk("R7 five ticks quiet", d, 8'h00);
    ticks(1);
    rd(2'd3, d); chk("R7 sixth tick suspend", d, 8'h20);
    chk("R8 suspend irq", {7'd0, irq}, 8'h01);
    wr(2'd3, 8'h20);
    ticks(3);
    rd(2'd3, d); chk("R7 no repeat", d, 8'h00);
    @(negedge clk);
    chk("R8 irq drops", {7'd0, irq}, 8'h00);
    activity(); ticks(3); activity(); ticks(3);
    rd(2'd3, d); chk("R7 activity restarts", d, 8'h00);
    @(negedge clk); tick = 1'b1; act = 1'b1;
    @(negedge clk); tick = 1'b0; act = 1'b0;
    ticks(5);
    rd(2'd3, d); chk("R7 activity beats tick", d, 8'h00);
    ticks(1);
    rd(2'd3, d); chk("R7 fires after restart", d, 8'h20);

    finish_run();
  end
endmodule